// File: doc/BRIEF.md
# ASCII to Six-Bit Case-Shift Encoder

This block turns a stream of ASCII characters into 8-bit tape frames. Each frame carries a 6-bit character code in its low bits and a parity bit in its top bit. The six-bit code set has no separate upper- and lower-case codes. The encoder therefore tracks which case is in force, and when a character belongs to the other case it first emits a case-shift code. The character itself is held and goes out on the following frame request. A single input character can therefore yield two frames.

Frames are pulled one at a time: a request pulse asks for the next frame, and the frame appears with a valid strobe. Arming the block queues a run of blank leader frames ahead of any text. Once the character source reports that it has nothing left, each request returns a stop code. Character translation uses an external lookup ROM. The encoder drives the ROM address from the incoming character and decodes the returned entry, so the full character table stays outside the block.

Top module: `asc6_encoder`

## Requirements
- R1: After reset, `frameValid` and `inReady` are 0, the case state is lower case, and no character is held, so a first upper-case character causes a shift frame.
- R2: A request pulse is accepted only when no request is outstanding, and each accepted request produces exactly one `frameValid` pulse. That pulse comes one cycle after the request is sampled, plus one cycle for each input character discarded on the way. Further requests while one is outstanding are ignored.
- R3: After an `arm` pulse, the next `LEADER_LEN` (default 20) frames are 8'h00, and no input is accepted while leader frames remain.
- R4: Every frame other than a leader frame has its code in bits 5:0, bit 6 at 0, and bit 7 set so that the frame holds an odd number of ones.
- R5: A ROM entry has the 6-bit code in bits 5:0, an upper-case flag in bit 6 and a both-cases flag in bit 7. `romAddr` is the input's low 7 bits, except that line feed (0x0A) is addressed as carriage return (0x0D).
- R6: When the entry has the both-cases flag set, or its upper-case flag equals the current case, the entry's code is emitted directly and the case state is unchanged.
- R7: Otherwise the case state takes the entry's flag and a shift code is emitted: octal 074 when switching to upper case, octal 072 when switching to lower case. The next request emits the held code without consuming input.
- R8: Bit 7 of `inData` is ignored, and an input carriage return (0x0D) is consumed and discarded without producing a frame.
- R9: A character whose ROM entry is zero is consumed and discarded, except space (0x20), which is translated using its entry as code 0 (frame 8'h80 in lower case).
- R10: When no held character or leader frame remains, `inValid` is 0 and `srcDone` is 1, a request yields the stop code, octal 013 (frame 8'h0B).
- R11: A request that finds no leader, no held character, no input and `srcDone` at 0 stays outstanding, with no frame, until input or `srcDone` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Pulse: queue the leader run |
| srcDone | input | 1 | Character source has no more input |
| inValid | input | 1 | Input character available |
| inReady | output | 1 | Encoder takes the character this cycle |
| inData | input | 8 | ASCII character; bit 7 ignored |
| romAddr | output | 7 | Lookup ROM address |
| romData | input | 8 | Lookup ROM entry, combinational reply |
| frameReq | input | 1 | Pulse: request the next frame |
| frameValid | output | 1 | One-cycle strobe: frameData holds a frame |
| frameData | output | 8 | Output tape frame |

## Verification
The hardest situation to reach is a held character colliding with other conditions. Examples are a shift arising while discardable characters sit in front of it, or an input arriving while a held character is still owed. The random stimulus builds streams that mix letters of both cases, digits, both-case characters, carriage returns, line feeds, unknown codes and set bit-7 values, so shifts land next to drops and immediately after re-arming. A directed idle-source scenario stalls a request with `srcDone` low, sends a second request that must be ignored, and then supplies one character.

// File: rtl/asc6_pkg.sv
package asc6_pkg;
  localparam int CODE_W = 6;
  localparam int CHAR_W = 7;

  localparam logic [CODE_W-1:0] SHIFT_UP   = 6'o74;
  localparam logic [CODE_W-1:0] SHIFT_DOWN = 6'o72;
  localparam logic [CODE_W-1:0] STOP_CODE  = 6'o13;

  localparam logic [CHAR_W-1:0] CH_LF    = 7'h0A;
  localparam logic [CHAR_W-1:0] CH_CR    = 7'h0D;
  localparam logic [CHAR_W-1:0] CH_SPACE = 7'h20;

  localparam int ENT_UPPER = 6;
  localparam int ENT_BOTH  = 7;

  typedef struct packed {
    logic leader;
    logic held;
    logic direct;
    logic shift;
    logic stop;
  } emitStrobes_t;

  function automatic logic [7:0] packFrame(input logic [CODE_W-1:0] code);
    return {~^code, 1'b0, code};
  endfunction
endpackage

// File: rtl/asc6_ctrl.sv
module asc6_ctrl
  import asc6_pkg::*;
#(
  parameter int LEADER_LEN = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               arm,
  input  logic               frameReq,
  input  logic               srcDone,
  input  logic               inValid,
  input  logic [CHAR_W-1:0]  inChar,
  input  logic [7:0]         romEntry,
  input  logic               caseUpper,
  input  logic               holdValid,
  output logic               inReady,
  output logic               busy,
  output logic               leaderBusy,
  output emitStrobes_t       strb
);
  localparam int CNT_W = $clog2(LEADER_LEN + 1);
  localparam logic [CNT_W-1:0] LEADER_LOAD = CNT_W'(LEADER_LEN);

  logic             pending;
  logic [CNT_W-1:0] leaderCnt;
  logic             take;
  logic             isCr;
  logic             entryDead;
  logic             keep;
  logic             caseOk;
  logic             fire;

  always_comb begin
    busy       = pending | frameReq;
    leaderBusy = (leaderCnt != '0);
    inReady    = busy & ~leaderBusy & ~holdValid;
    take       = inReady & inValid;
    isCr       = (inChar == CH_CR);
    entryDead  = (romEntry == 8'h00) & (inChar != CH_SPACE);
    keep       = take & ~isCr & ~entryDead;
    caseOk     = romEntry[ENT_BOTH] | (romEntry[ENT_UPPER] == caseUpper);

    strb.leader = busy & leaderBusy;
    strb.held   = busy & ~leaderBusy & holdValid;
    strb.direct = keep & caseOk;
    strb.shift  = keep & ~caseOk;
    strb.stop   = busy & ~leaderBusy & ~holdValid & ~inValid & srcDone;
    fire        = |strb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      leaderCnt <= '0;
    end else begin
      pending <= busy & ~fire;
      if (arm)
        leaderCnt <= LEADER_LOAD;
      else if (strb.leader)
        leaderCnt <= leaderCnt - 1'b1;
    end
  end
endmodule

// File: rtl/asc6_datapath.sv
module asc6_datapath
  import asc6_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  emitStrobes_t      strb,
  input  logic [7:0]        romEntry,
  output logic              caseUpper,
  output logic              holdValid,
  output logic              frameValid,
  output logic [7:0]        frameData
);
  logic [CODE_W-1:0] holdCode;
  logic [CODE_W-1:0] outCode;
  logic [CODE_W-1:0] entryCode;
  logic              entryUpper;

  always_comb begin
    entryCode  = romEntry[CODE_W-1:0];
    entryUpper = romEntry[ENT_UPPER];
    unique case (1'b1)
      strb.held:   outCode = holdCode;
      strb.direct: outCode = entryCode;
      strb.shift:  outCode = entryUpper ? SHIFT_UP : SHIFT_DOWN;
      default:     outCode = STOP_CODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      caseUpper  <= 1'b0;
      holdValid  <= 1'b0;
      holdCode   <= '0;
      frameValid <= 1'b0;
      frameData  <= 8'h00;
    end else begin
      frameValid <= |strb;
      if (strb.leader)
        frameData <= 8'h00;
      else if (|strb)
        frameData <= packFrame(outCode);
      if (strb.shift) begin
        caseUpper <= entryUpper;
        holdCode  <= entryCode;
        holdValid <= 1'b1;
      end else if (strb.held) begin
        holdValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/asc6_encoder.sv
module asc6_encoder
  import asc6_pkg::*;
#(
  parameter int LEADER_LEN = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        arm,
  input  logic        srcDone,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  inData,
  output logic [6:0]  romAddr,
  input  logic [7:0]  romData,
  input  logic        frameReq,
  output logic        frameValid,
  output logic [7:0]  frameData
);
  logic [CHAR_W-1:0] inChar;
  logic              caseUpper;
  logic              holdValid;
  logic              busy;
  logic              leaderBusy;
  emitStrobes_t      strb;

  assign inChar  = inData[CHAR_W-1:0];
  assign romAddr = (inChar == CH_LF) ? CH_CR : inChar;

  asc6_ctrl #(.LEADER_LEN(LEADER_LEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .arm        (arm),
    .frameReq   (frameReq),
    .srcDone    (srcDone),
    .inValid    (inValid),
    .inChar     (inChar),
    .romEntry   (romData),
    .caseUpper  (caseUpper),
    .holdValid  (holdValid),
    .inReady    (inReady),
    .busy       (busy),
    .leaderBusy (leaderBusy),
    .strb       (strb)
  );

  asc6_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .romEntry   (romData),
    .caseUpper  (caseUpper),
    .holdValid  (holdValid),
    .frameValid (frameValid),
    .frameData  (frameData)
  );
endmodule

// File: rtl/asc6_encoder_chk.sv
module asc6_encoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inReady,
  input logic       frameValid,
  input logic [7:0] frameData,
  input logic       busy,
  input logic       leaderBusy,
  input logic       holdValid,
  input logic       caseUpper
);
  p_frame_format_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameData != 8'h00) |->
      (!frameData[6] && ($countones(frameData) % 2 == 1)));

  p_leader_blocks_input_r3: assert property (@(posedge clk) disable iff (!rstN)
    leaderBusy |-> !inReady);

  p_frame_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> $past(busy));

  p_hold_from_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdValid) |-> (frameValid &&
      (frameData[5:0] == 6'o74 || frameData[5:0] == 6'o72)));

  p_hold_blocks_input_r7: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> !inReady);

  p_hold_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdValid) |-> frameValid);

  p_case_follows_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(caseUpper) |->
      (frameValid && frameData[5:0] == (caseUpper ? 6'o74 : 6'o72)));
endmodule

bind asc6_encoder asc6_encoder_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inReady    (inReady),
  .frameValid (frameValid),
  .frameData  (frameData),
  .busy       (busy),
  .leaderBusy (leaderBusy),
  .holdValid  (holdValid),
  .caseUpper  (caseUpper)
);

// File: tb/asc6_encoder_bench.sv
module asc6_encoder_bench;
  localparam int LEADER_LEN = 20;
  localparam int BUF_LEN = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       arm = 1'b0;
  logic       srcDone = 1'b1;
  logic       inValid;
  logic       inReady;
  logic [7:0] inData;
  logic [6:0] romAddr;
  logic [7:0] romData;
  logic       frameReq = 1'b0;
  logic       frameValid;
  logic [7:0] frameData;

  logic [7:0] stream [BUF_LEN];
  int         len = 0;
  int         idx = 0;

  int nChecks = 0;
  int nFail = 0;

  int         mLeader = 0;
  logic       mCase = 1'b0;
  logic       mHeldV = 1'b0;
  logic [5:0] mHeld = '0;
  int         midx = 0;
  logic [7:0] lastFrame;

  always #5 clk = ~clk;

  asc6_encoder #(.LEADER_LEN(LEADER_LEN)) u_asc6_encoder (
    .clk(clk), .rstN(rstN), .arm(arm), .srcDone(srcDone),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .romAddr(romAddr), .romData(romData),
    .frameReq(frameReq), .frameValid(frameValid), .frameData(frameData)
  );

  function automatic logic [7:0] romModel(input logic [6:0] a);
    if (a == 7'h0D) return 8'h80 | 8'o077;
    if (a == 7'h09) return 8'h80 | 8'o036;
    if (a == 7'h20) return 8'h00;
    if (a == "0") return 8'o020;
    if (a >= "1" && a <= "9") return 8'(a - 7'h30);
    if (a >= "a" && a <= "i") return 8'(8'o061 + (a - "a"));
    if (a >= "j" && a <= "r") return 8'(8'o041 + (a - "j"));
    if (a >= "s" && a <= "z") return 8'(8'o022 + (a - "s"));
    if (a >= "A" && a <= "I") return 8'(8'o161 + (a - "A"));
    if (a >= "J" && a <= "R") return 8'(8'o141 + (a - "J"));
    if (a >= "S" && a <= "Z") return 8'(8'o122 + (a - "S"));
    return 8'h00;
  endfunction

  function automatic logic [7:0] frm(input logic [5:0] code);
    logic par;
    par = ($countones(code) % 2 == 0);
    return {par, 1'b0, code};
  endfunction

  always_comb romData = romModel(romAddr);
  assign inValid = (idx < len);
  assign inData  = (idx < len) ? stream[idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (inValid && inReady) idx <= idx + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] c);
    stream[len] = c;
    len++;
  endtask

  task automatic modelNext(output logic [7:0] exp, output int drops);
    logic [6:0] c;
    logic [7:0] e;
    drops = 0;
    if (mLeader > 0) begin
      mLeader--;
      exp = 8'h00;
      return;
    end
    if (mHeldV) begin
      mHeldV = 1'b0;
      exp = frm(mHeld);
      return;
    end
    while (midx < len) begin
      c = stream[midx][6:0];
      midx++;
      if (c == 7'h0D) begin drops++; continue; end
      e = romModel((c == 7'h0A) ? 7'h0D : c);
      if (e == 8'h00 && c != 7'h20) begin drops++; continue; end
      if (e[7] || e[6] == mCase) exp = frm(e[5:0]);
      else begin
        mCase = e[6];
        mHeld = e[5:0];
        mHeldV = 1'b1;
        exp = frm(mCase ? 6'o74 : 6'o72);
      end
      return;
    end
    exp = frm(6'o13);
  endtask

  task automatic getFrame(input string tag);
    logic [7:0] exp;
    int drops;
    int waited;
    modelNext(exp, drops);
    @(negedge clk) frameReq = 1'b1;
    @(negedge clk) frameReq = 1'b0;
    waited = 0;
    while (!frameValid && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    chk(tag, frameData, exp);
    chk({tag, " R2 latency"}, waited, drops);
    chk({tag, " input count"}, idx, midx);
    lastFrame = exp;
  endtask

  task automatic doArm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
    mLeader = LEADER_LEN;
  endtask

  task automatic pushRandom();
    int k;
    logic [7:0] c;
    k = $urandom_range(0, 9);
    case (k)
      0, 1: c = 8'("a" + $urandom_range(0, 25));
      2, 3: c = 8'("A" + $urandom_range(0, 25));
      4:    c = 8'("0" + $urandom_range(0, 9));
      5:    c = 8'h20;
      6:    c = 8'h0D;
      7:    c = 8'h0A;
      8:    c = 8'h09;
      default: c = ($urandom_range(0, 1) != 0) ? 8'h24 : 8'h7F;
    endcase
    if ($urandom_range(0, 3) == 0) c[7] = 1'b1;
    push(c);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #1000000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int waited;
    int extra;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 frameValid", frameValid, 0);
    chk("R1 inReady", inReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", frameValid, 0);

    // R1 R7: first upper-case char shifts from reset lower case
    push("A"); push("b");
    getFrame("R1 R7 shift up");
    chk("R7 shift up frame", frameData, 8'hBC);
    getFrame("R7 held char");
    getFrame("R7 shift down");
    chk("R7 shift down frame", frameData, 8'hBA);
    getFrame("R7 held lower");

    // R6: same-case and both-case characters emit directly
    push("c"); push(8'h09); push("7");
    getFrame("R6 same case");
    getFrame("R6 both case tab");
    getFrame("R6 digit");

    // R8: bit 7 ignored, CR dropped, LF becomes CR code
    push(8'h80 | "d"); push(8'h0D); push(8'h0A);
    getFrame("R8 bit7 ignored");
    getFrame("R8 R5 CR drop then LF");
    chk("R8 LF frame", frameData, 8'hBF);

    // R9: unknown dropped, space with zero entry kept
    push(8'h24); push(8'h20);
    getFrame("R9 space");
    chk("R9 space frame", frameData, 8'h80);

    // R10: stop code when exhausted
    getFrame("R10 stop");
    chk("R10 stop frame", frameData, 8'h0B);

    // R3: leader after arm, input held back
    push("e");
    doArm();
    for (int i = 0; i < LEADER_LEN; i++) getFrame("R3 leader");
    getFrame("R3 after leader");

    // R11 and R2: stalled request, second request ignored
    srcDone = 1'b0;
    @(negedge clk) frameReq = 1'b1;
    @(negedge clk) frameReq = 1'b0;
    waited = 0;
    repeat (4) begin
      @(negedge clk);
      if (frameValid) waited++;
    end
    chk("R11 no frame while idle", waited, 0);
    frameReq = 1'b1;
    @(negedge clk) frameReq = 1'b0;
    push("f");
    midx = midx + 1;
    @(negedge clk);
    chk("R11 frame on arrival", frameValid, 1);
    chk("R11 frame value", frameData, frm(6'o66));
    extra = 0;
    repeat (5) begin
      @(negedge clk);
      if (frameValid) extra++;
    end
    chk("R2 extra request ignored", extra, 0);
    srcDone = 1'b1;

    // random rounds
    for (int r = 0; r < 10; r++) begin
      if (r % 3 == 1) doArm();
      for (int n = 0; n < 16; n++) pushRandom();
      for (int g = 0; g < 80; g++) begin
        getFrame("R4 R6 R7 R8 R9 random");
        if (lastFrame == 8'h0B && midx == len && !mHeldV && mLeader == 0) break;
      end
      chk("R10 random stop", lastFrame, 8'h0B);
    end
    finishRun();
  end
endmodule